// File: doc/BRIEF.md
# Parameterized Combinational ALU with Condition Flags

This block is a purely combinational arithmetic and logic unit for a datapath of configurable width (16 bits by default). Two operand words and a 4-bit operation code select one of sixteen fixed functions. The functions are add, subtract, increment, decrement, four bitwise operations, single-position shifts and rotates, and three magnitude tests. Alongside the result word it reports four condition bits: zero, negative, carry and signed overflow. A surrounding pipeline can latch these bits into its status state.

An enable input gates the whole unit. While it is low, the result and every flag read as zero, whatever the operation code and operands are. No state is held inside the block, so outputs follow inputs within the same cycle. The width parameter must be 2 or more. Every flag rule scales with it.

Top module: `alu_unit`

## Requirements
- R1: Code 0000 gives A+B modulo 2^WIDTH. Carry is the carry-out of the sum. Overflow is set when A and B share a sign bit and the result sign differs from it.
- R2: Code 0001 gives A-B modulo 2^WIDTH. Carry is set when a borrow occurs, meaning A < B unsigned. Overflow is set when A and B differ in sign and the result sign differs from A.
- R3: Code 0010 gives A+1 and code 0011 gives A-1. Carry and overflow follow R1 and R2 respectively, with B taken as 1.
- R4: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, A XOR B and NOT A. Carry and overflow are both 0.
- R5: Code 1000 shifts A left by one and fills the LSB with 0, and carry receives the old MSB. Code 1001 shifts A right by one and fills the MSB with 0, and carry receives the old LSB.
- R6: Code 1010 shifts A right by one and keeps the old MSB in the top bit, and carry receives the old LSB.
- R7: Code 1011 rotates A left by one, and carry receives the old MSB. Code 1100 rotates A right by one, and carry receives the old LSB.
- R8: Codes 1101, 1110 and 1111 give the value 1 when A == B, A > B and A < B respectively, and 0 otherwise. A and B are compared as unsigned values, and carry is 0.
- R9: When enabled, the zero flag is 1 exactly when the result word is all zeros.
- R10: When enabled, the negative flag equals bit WIDTH-1 of the result.
- R11: When enable is 0, the result, zero, negative, carry and overflow outputs are all 0 for every code and operand.
- R12: Overflow is 0 for every code from 0100 to 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aIn | input | WIDTH | First operand |
| bIn | input | WIDTH | Second operand |
| opSel | input | 4 | Operation code |
| enable | input | 1 | Unit enable; low forces all outputs to zero |
| result | output | WIDTH | Result word |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Result MSB |
| carryFlag | output | 1 | Carry-out, borrow or bit shifted out |
| ovfFlag | output | 1 | Signed overflow on arithmetic codes |

## Verification
The bench builds two instances: one at the default width of 16 and one at a width of 4. The 4-bit instance is small enough to sweep every operation code against every operand pair. That sweep reaches each sign-bit crossing, wraparound and borrow case, and it tests the flag rules at a width other than the default. The 16-bit instance runs hand-worked corner vectors (most-negative values, all-ones operands, equal operands, and signed versus unsigned ordering) and a pseudo-random sweep checked against a behavioural model. It also runs every code with enable low.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'b0000, OP_SUB = 4'b0001, OP_INC = 4'b0010, OP_DEC = 4'b0011,
    OP_AND = 4'b0100, OP_OR  = 4'b0101, OP_XOR = 4'b0110, OP_NOT = 4'b0111,
    OP_SHL = 4'b1000, OP_SHR = 4'b1001, OP_ASR = 4'b1010, OP_ROL = 4'b1011,
    OP_ROR = 4'b1100, OP_EQ  = 4'b1101, OP_GT  = 4'b1110, OP_LT  = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT, UNIT_CMP} unit_e;
  typedef enum logic [1:0] {LOG_AND, LOG_OR, LOG_XOR, LOG_NOT} logic_e;
  typedef enum logic [1:0] {FILL_ZERO, FILL_SIGN, FILL_WRAP} fill_e;
  typedef enum logic [1:0] {CMP_EQ, CMP_GT, CMP_LT} cmp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    unit_e  unit;
    logic   negateB;    // form A + ~B + 1
    logic   unitB;      // replace B by the constant 1
    logic_e logicSel;
    logic   shiftRight;
    fill_e  fill;
    cmp_e   cmpSel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] opSel,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{unit: UNIT_ARITH, negateB: 1'b0, unitB: 1'b0, logicSel: LOG_AND,
             shiftRight: 1'b0, fill: FILL_ZERO, cmpSel: CMP_EQ};
    case (alu_op_e'(opSel))
      OP_ADD: ctrl.unit = UNIT_ARITH;
      OP_SUB: ctrl.negateB = 1'b1;
      OP_INC: ctrl.unitB = 1'b1;
      OP_DEC: begin ctrl.unitB = 1'b1; ctrl.negateB = 1'b1; end
      OP_AND: begin ctrl.unit = UNIT_LOGIC; ctrl.logicSel = LOG_AND; end
      OP_OR:  begin ctrl.unit = UNIT_LOGIC; ctrl.logicSel = LOG_OR;  end
      OP_XOR: begin ctrl.unit = UNIT_LOGIC; ctrl.logicSel = LOG_XOR; end
      OP_NOT: begin ctrl.unit = UNIT_LOGIC; ctrl.logicSel = LOG_NOT; end
      OP_SHL: begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_ZERO; end
      OP_SHR: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftRight = 1'b1; ctrl.fill = FILL_ZERO; end
      OP_ASR: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftRight = 1'b1; ctrl.fill = FILL_SIGN; end
      OP_ROL: begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_WRAP; end
      OP_ROR: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftRight = 1'b1; ctrl.fill = FILL_WRAP; end
      OP_EQ:  begin ctrl.unit = UNIT_CMP; ctrl.cmpSel = CMP_EQ; end
      OP_GT:  begin ctrl.unit = UNIT_CMP; ctrl.cmpSel = CMP_GT; end
      OP_LT:  begin ctrl.unit = UNIT_CMP; ctrl.cmpSel = CMP_LT; end
      default: ctrl.unit = UNIT_ARITH;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] rawResult,
  output logic             rawCarry,
  output logic             rawOvf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] operandB;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;
  logic             arithCarry;
  logic             arithOvf;
  logic [WIDTH-1:0] logicOut;
  logic             shiftIn;
  logic [WIDTH-1:0] shiftOut;
  logic             shiftCarry;
  logic             cmpBit;

  // One shared adder serves add, subtract, increment and decrement
  always_comb begin
    operandB   = ctrl.unitB ? WIDTH'(1) : bIn;
    addend     = ctrl.negateB ? ~operandB : operandB;
    sum        = {1'b0, aIn} + {1'b0, addend} + {{WIDTH{1'b0}}, ctrl.negateB};
    arithCarry = ctrl.negateB ? ~sum[WIDTH] : sum[WIDTH];
    arithOvf   = (aIn[MSB] == addend[MSB]) && (sum[MSB] != aIn[MSB]);
  end

  always_comb begin
    case (ctrl.logicSel)
      LOG_AND: logicOut = aIn & bIn;
      LOG_OR:  logicOut = aIn | bIn;
      LOG_XOR: logicOut = aIn ^ bIn;
      default: logicOut = ~aIn;
    endcase
  end

  // Single-position shifter; the fill bit picks logical, arithmetic or rotate
  always_comb begin
    case (ctrl.fill)
      FILL_SIGN: shiftIn = aIn[MSB];
      FILL_WRAP: shiftIn = ctrl.shiftRight ? aIn[0] : aIn[MSB];
      default:   shiftIn = 1'b0;
    endcase
    if (ctrl.shiftRight) begin
      shiftOut   = {shiftIn, aIn[MSB:1]};
      shiftCarry = aIn[0];
    end else begin
      shiftOut   = {aIn[MSB-1:0], shiftIn};
      shiftCarry = aIn[MSB];
    end
  end

  always_comb begin
    case (ctrl.cmpSel)
      CMP_EQ:  cmpBit = (aIn == bIn);
      CMP_GT:  cmpBit = (aIn > bIn);
      default: cmpBit = (aIn < bIn);
    endcase
  end

  always_comb begin
    rawResult = '0;
    rawCarry  = 1'b0;
    rawOvf    = 1'b0;
    case (ctrl.unit)
      UNIT_ARITH: begin
        rawResult = sum[MSB:0];
        rawCarry  = arithCarry;
        rawOvf    = arithOvf;
      end
      UNIT_LOGIC: rawResult = logicOut;
      UNIT_SHIFT: begin
        rawResult = shiftOut;
        rawCarry  = shiftCarry;
      end
      default: rawResult = {{(WIDTH-1){1'b0}}, cmpBit};
    endcase
  end

endmodule

// File: rtl/alu_flagger.sv
module alu_flagger #(
  parameter int WIDTH = 16
) (
  input  logic             enable,
  input  logic [WIDTH-1:0] rawResult,
  input  logic             rawCarry,
  input  logic             rawOvf,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             carryFlag,
  output logic             ovfFlag
);

  always_comb begin
    result    = enable ? rawResult : '0;
    zeroFlag  = enable && (rawResult == '0);
    negFlag   = enable && rawResult[WIDTH-1];
    carryFlag = enable && rawCarry;
    ovfFlag   = enable && rawOvf;
  end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic [3:0]       opSel,
  input  logic             enable,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             carryFlag,
  output logic             ovfFlag
);

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] rawResult;
  logic             rawCarry;
  logic             rawOvf;

  alu_decode u_decode (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .aIn       (aIn),
    .bIn       (bIn),
    .ctrl      (ctrl),
    .rawResult (rawResult),
    .rawCarry  (rawCarry),
    .rawOvf    (rawOvf)
  );

  alu_flagger #(.WIDTH(WIDTH)) u_flagger (
    .enable    (enable),
    .rawResult (rawResult),
    .rawCarry  (rawCarry),
    .rawOvf    (rawOvf),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .negFlag   (negFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag)
  );

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [3:0]       opSel,
  input logic             enable,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             negFlag,
  input logic             carryFlag,
  input logic             ovfFlag
);

  always_comb begin
    // R11: disabled unit is silent
    p_quiet_when_off_r11: assert (enable || ({result, zeroFlag, negFlag, carryFlag, ovfFlag} == '0))
      else $error("disabled unit drives a nonzero output");
    // R9
    p_zero_matches_r9: assert (!enable || (zeroFlag == (result == '0)))
      else $error("zero flag disagrees with result");
    // R10
    p_neg_matches_r10: assert (!enable || (negFlag == result[WIDTH-1]))
      else $error("negative flag disagrees with result MSB");
    // R12
    p_no_overflow_r12: assert (!(enable && opSel[3:2] != 2'b00) || !ovfFlag)
      else $error("overflow set on non-arithmetic code");
    // R4
    p_logic_no_carry_r4: assert (!(enable && opSel[3:2] == 2'b01) || !carryFlag)
      else $error("carry set on bitwise code");
    // R8
    p_cmp_single_bit_r8: assert (!(enable && opSel >= 4'b1101) || (result[WIDTH-1:1] == '0 && !carryFlag))
      else $error("comparison result wider than one bit");
    // R1
    p_add_sum_r1: assert (!(enable && opSel == 4'b0000) || ({carryFlag, result} == ({1'b0, aIn} + {1'b0, bIn})))
      else $error("add result mismatch");
  end

endmodule

bind alu_unit alu_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .aIn       (aIn),
  .bIn       (bIn),
  .opSel     (opSel),
  .enable    (enable),
  .result    (result),
  .zeroFlag  (zeroFlag),
  .negFlag   (negFlag),
  .carryFlag (carryFlag),
  .ovfFlag   (ovfFlag)
);

// File: tb/sim_alu_unit.sv
module sim_alu_unit;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // 16-bit instance
  logic [15:0] a0 = '0, b0 = '0;
  logic [3:0]  op0 = '0;
  logic        en0 = 1'b0;
  logic [15:0] res0;
  logic        z0, n0, c0, v0;

  // 4-bit instance
  logic [3:0] a1 = '0, b1 = '0;
  logic [3:0] op1 = '0;
  logic       en1 = 1'b0;
  logic [3:0] res1;
  logic       z1, n1, c1, v1;

  alu_unit #(.WIDTH(16)) u0 (
    .aIn(a0), .bIn(b0), .opSel(op0), .enable(en0), .result(res0),
    .zeroFlag(z0), .negFlag(n0), .carryFlag(c0), .ovfFlag(v0)
  );

  alu_unit #(.WIDTH(4)) u1 (
    .aIn(a1), .bIn(b1), .opSel(op1), .enable(en1), .result(res1),
    .zeroFlag(z1), .negFlag(n1), .carryFlag(c1), .ovfFlag(v1)
  );

  // Vector: op, A, B, expected result, expected {zero,neg,carry,ovf}, requirement
  typedef logic [59:0] vec_t;
  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    {4'h0, 16'h7FFF, 16'h0001, 16'h8000, 4'b0101, 4'd1},  // R1 signed overflow
    {4'h0, 16'hFFFF, 16'h0001, 16'h0000, 4'b1010, 4'd1},  // R1 carry out, zero
    {4'h0, 16'h8000, 16'h8000, 16'h0000, 4'b1011, 4'd1},  // R1 carry and overflow
    {4'h1, 16'h0005, 16'h0007, 16'hFFFE, 4'b0110, 4'd2},  // R2 borrow
    {4'h1, 16'h8000, 16'h0001, 16'h7FFF, 4'b0001, 4'd2},  // R2 overflow
    {4'h1, 16'h1234, 16'h1234, 16'h0000, 4'b1000, 4'd2},  // R2 equal operands
    {4'h2, 16'h7FFF, 16'h0000, 16'h8000, 4'b0101, 4'd3},  // R3 increment overflow
    {4'h2, 16'hFFFF, 16'h0000, 16'h0000, 4'b1010, 4'd3},  // R3 increment wrap
    {4'h3, 16'h0000, 16'h0000, 16'hFFFF, 4'b0110, 4'd3},  // R3 decrement borrow
    {4'h3, 16'h8000, 16'h0000, 16'h7FFF, 4'b0001, 4'd3},  // R3 decrement overflow
    {4'h4, 16'hF0F0, 16'h0FF0, 16'h00F0, 4'b0000, 4'd4},  // R4 AND
    {4'h5, 16'h8000, 16'h0001, 16'h8001, 4'b0100, 4'd4},  // R4 OR
    {4'h6, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b1000, 4'd4},  // R4 XOR
    {4'h7, 16'h0000, 16'hFFFF, 16'hFFFF, 4'b0100, 4'd4},  // R4 NOT
    {4'h8, 16'h8001, 16'h0000, 16'h0002, 4'b0010, 4'd5},  // R5 shift left
    {4'h9, 16'h0003, 16'h0000, 16'h0001, 4'b0010, 4'd5},  // R5 shift right
    {4'hA, 16'h8002, 16'h0000, 16'hC001, 4'b0100, 4'd6},  // R6 sign kept
    {4'hA, 16'h4001, 16'h0000, 16'h2000, 4'b0010, 4'd6},  // R6 positive
    {4'hB, 16'h8001, 16'h0000, 16'h0003, 4'b0010, 4'd7},  // R7 rotate left
    {4'hC, 16'h0001, 16'h0000, 16'h8000, 4'b0110, 4'd7},  // R7 rotate right
    {4'hD, 16'h5555, 16'h5555, 16'h0001, 4'b0000, 4'd8},  // R8 equal
    {4'hD, 16'h5555, 16'h5554, 16'h0000, 4'b1000, 4'd8},  // R8 not equal
    {4'hE, 16'h8000, 16'h7FFF, 16'h0001, 4'b0000, 4'd8},  // R8 unsigned greater
    {4'hF, 16'h8000, 16'h7FFF, 16'h0000, 4'b1000, 4'd8},  // R8 unsigned not less
    {4'hF, 16'h0001, 16'hFFFF, 16'h0001, 4'b0000, 4'd8}   // R8 less
  };

  // Behavioural model from the requirements; operands already fit in w bits.
  // Returns {zero, neg, carry, ovf, result}
  function automatic logic [19:0] refModel(input logic [3:0] op, input logic [15:0] a,
                                           input logic [15:0] b, input int w);
    logic [15:0] mask;
    logic [16:0] s;
    logic [15:0] r;
    logic c, v, aS, bS;
    int m;
    m    = w - 1;
    mask = (w == 16) ? 16'hFFFF : 16'((17'h1 << w) - 1);
    aS   = a[m];
    bS   = b[m];
    c    = 1'b0;
    v    = 1'b0;
    s    = '0;
    case (op)
      4'h0: begin s = {1'b0, a} + {1'b0, b}; r = s[15:0] & mask; c = s[w]; v = (aS == bS) && (r[m] != aS); end
      4'h1: begin r = (a - b) & mask; c = (a < b); v = (aS != bS) && (r[m] != aS); end
      4'h2: begin s = {1'b0, a} + 17'd1; r = s[15:0] & mask; c = s[w]; v = !aS && r[m]; end
      4'h3: begin r = (a - 16'd1) & mask; c = (a == 16'd0); v = aS && !r[m]; end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~a & mask;
      4'h8: begin r = (a << 1) & mask; c = aS; end
      4'h9: begin r = a >> 1; c = a[0]; end
      4'hA: begin r = (a >> 1) | (16'(aS) << m); c = a[0]; end
      4'hB: begin r = ((a << 1) | 16'(aS)) & mask; c = aS; end
      4'hC: begin r = (a >> 1) | (16'(a[0]) << m); c = a[0]; end
      4'hD: r = 16'(a == b);
      4'hE: r = 16'(a > b);
      default: r = 16'(a < b);
    endcase
    return {(r == 16'd0), r[m], c, v, r};
  endfunction

  function automatic int reqOf(input logic [3:0] op);
    case (op)
      4'h0: return 1;
      4'h1: return 2;
      4'h2, 4'h3: return 3;
      4'h4, 4'h5, 4'h6, 4'h7: return 4;
      4'h8, 4'h9: return 5;
      4'hA: return 6;
      4'hB, 4'hC: return 7;
      default: return 8;
    endcase
  endfunction

  task automatic check(input int req, input logic [19:0] got, input logic [19:0] exp, input string what);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL R%0d %s: got z%b n%b c%b v%b res=%h, expected z%b n%b c%b v%b res=%h",
               req, what, got[19], got[18], got[17], got[16], got[15:0],
               exp[19], exp[18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
      finish();
    end
  end

  initial begin
    logic [31:0] lfsr;
    // R11: unit starts disabled, all outputs zero
    @(negedge clk);
    check(11, {z0, n0, c0, v0, res0}, 20'h0, "initial disabled state");

    // Table of corner vectors; R9 and R10 are covered by the expected flags
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      en0 = 1'b1;
      op0 = VECS[i][59:56];
      a0  = VECS[i][55:40];
      b0  = VECS[i][39:24];
      @(negedge clk);
      check(int'(VECS[i][3:0]), {z0, n0, c0, v0, res0}, {VECS[i][7:4], VECS[i][23:8]}, "corner vector");
    end

    // R11: every code with enable low, operands that would give nonzero outputs
    for (int k = 0; k < 16; k++) begin
      @(posedge clk);
      en0 = 1'b0;
      op0 = 4'(k);
      a0  = 16'hFFFF;
      b0  = 16'h8001;
      @(negedge clk);
      check(11, {z0, n0, c0, v0, res0}, 20'h0, "enable low");
    end

    // R12 and R1..R8: exhaustive sweep of the 4-bit instance
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          en1 = 1'b1;
          op1 = 4'(op);
          a1  = 4'(a);
          b1  = 4'(b);
          @(negedge clk);
          check(reqOf(4'(op)), {z1, n1, c1, v1, 12'h0, res1},
                refModel(4'(op), 16'(a), 16'(b), 4), "width-4 sweep");
        end
      end
    end

    // Pseudo-random sweep of the 16-bit instance
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      en0 = 1'b1;
      op0 = 4'(i % 16);
      a0  = lfsr[15:0];
      b0  = (i % 7 == 0) ? lfsr[15:0] : lfsr[31:16];
      @(negedge clk);
      check(reqOf(op0), {z0, n0, c0, v0, res0}, refModel(op0, a0, b0, 16), "width-16 random");
    end

    // R11 after activity: dropping enable clears a live result
    @(posedge clk);
    op0 = 4'h7;
    a0  = 16'h0000;
    en0 = 1'b0;
    @(negedge clk);
    check(11, {z0, n0, c0, v0, res0}, 20'h0, "enable dropped on NOT");

    finish();
  end

endmodule